// File: doc/BRIEF.md
# PHY Temperature Measurement Sequencer

This block takes one on-die temperature reading through a PHY's register-access port. After a `start` pulse it first proves the access path by writing three patterns to a scratch register and reading each one back. A mismatch raises `rw_err`, but the run still goes on. It then saves three PHY test registers and forces a measurement setup. It runs two averaged ADC measurements, m1 and m2, with an analog-select bit cleared for the first and set for the second. Finally it writes the saved registers back and turns the two readings into a signed temperature value with a fixed quadratic.

The register port carries one command at a time: `reg_req` stays high, with address, direction and write data stable, until the PHY side returns `reg_ack`. Read data arrives on `reg_rdata` in the `reg_ack` cycle. The averaging engine is external. The block pulses `avg_start` and waits for `avg_done`, taking `avg_result` in that cycle.

The sequence uses these states:

| State | Role |
|-------|------|
| ST_IDLE | Waits for `start`. |
| ST_REG_ISSUE | Holds one register command until `reg_ack`. |
| ST_STEP_NEXT | Picks the next step. |
| ST_AVG_GO | Pulses `avg_start`. |
| ST_AVG_WAIT | Waits for `avg_done`. |
| ST_DIV_GO | Launches the serial divider. |
| ST_DIV_WAIT | Waits for the divider. |
| ST_FINISH | Raises `done` for one cycle. |

The transitions are:

- ST_IDLE goes to ST_REG_ISSUE when `start` is high.
- ST_REG_ISSUE goes to ST_STEP_NEXT when `reg_ack` is high.
- ST_STEP_NEXT goes to ST_AVG_GO when the step is a measurement, to ST_DIV_GO once all 18 steps are done, and to ST_REG_ISSUE otherwise.
- ST_AVG_GO goes to ST_AVG_WAIT.
- ST_AVG_WAIT goes to ST_STEP_NEXT when `avg_done` is high.
- ST_DIV_GO goes to ST_DIV_WAIT.
- ST_DIV_WAIT goes to ST_FINISH when the divider finishes.
- ST_FINISH goes to ST_IDLE.

Top module: `temp_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `reg_req`, `avg_start` and `rw_err` are all low.
- R2: A run begins with six commands to address 0x0001, in this order: write 0x0000, read, write 0x5A5A, read, write 0x1234, read.
- R3: If any of the three scratch reads differs from the value just written, `rw_err` is high when `done` pulses, and the run still completes. `rw_err` is cleared when a new run starts.
- R4: After the scratch test, registers 0x0017, 0x0009 and 0x0008 are read, in that order, and their values are saved.
- R5: The next two writes go to 0x0017 with bits [12:2] set to 512 and to 0x0008 with bits [14:12] set to 4. All other bits keep their saved values.
- R6: Each measurement follows its own write to 0x0009, which sets bits [1:0] to 1 and keeps the other bits as saved. Bit 4 is 0 for m1 and 1 for m2. `avg_start` is a one-cycle pulse, and nothing else happens between the two writes and their measurements.
- R7: After m2, registers 0x0017, 0x0008 and 0x0009 are written in that order with their saved fields merged back, which yields the values read in R4.
- R8: `reg_req` stays high with stable `reg_addr`, `reg_we` and `reg_wdata` until `reg_ack`. A run issues exactly 16 register commands.
- R9: The block computes `a = (m2e - m1) / (m2e / 1000)`. Here `m2e` is 1000 when `m2 / 1000` is zero and is `m2` otherwise. All divisions truncate toward zero.
- R10: `temp_out` = (-559·a·a)/1000 + 1379·a - 458000, in signed 48-bit arithmetic. It is valid when the one-cycle `done` pulse appears and holds until the next `done`.
- R11: `start` has no effect while a run is in progress. After `done`, the block stays idle with no further commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reading (ignored unless idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| rw_err | output | 1 | Scratch read-back mismatch seen in this run |
| reg_req | output | 1 | Register command pending |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 16 | PHY register address |
| reg_wdata | output | 16 | Write data (zero on reads) |
| reg_ack | input | 1 | Command complete |
| reg_rdata | input | 16 | Read data, valid with `reg_ack` |
| avg_start | output | 1 | Launch one averaged measurement |
| avg_done | input | 1 | Averaged result ready |
| avg_result | input | AVG_W | Averaged measurement (unsigned) |
| temp_out | output | CALC_W | Signed temperature value |

## Verification
The bench sweeps a grid of m1 and m2 values against a register model that holds different saved contents in every run:

- m2 values of zero and just below 1000 test the divisor substitution.
- m2 of exactly 1000 gives a unit divisor without substitution.
- Cases with m1 larger than m2 give a negative `a`, which tests truncation toward zero and the sign of the quadratic.

Acknowledge and averager latencies vary between runs. Each run corrupts either none or one chosen scratch read, which separates a correct mismatch flag from one stuck at a value or tied to a single pattern. A stray `start` during every run shows whether the sequence restarts. The register model records every command, and the model contents are checked at each measurement launch. Together these confirm the field patching, the bit 4 polarity for m1 and m2, and the final restore.

// File: rtl/temp_seq_pkg.sv
package temp_seq_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 16;
    localparam int STEP_W = 5;

    // Step numbering of the sequence; measurement steps sit between register commands.
    localparam int STEP_M1  = 12;
    localparam int STEP_M2  = 14;
    localparam int STEP_END = 18;

    localparam logic [ADDR_W-1:0] A_SCRATCH = 16'h0001;
    localparam logic [ADDR_W-1:0] A_DACCFG  = 16'h0008;
    localparam logic [ADDR_W-1:0] A_TUNE    = 16'h0009;
    localparam logic [ADDR_W-1:0] A_PLLTEST = 16'h0017;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REG_ISSUE,
        ST_STEP_NEXT,
        ST_AVG_GO,
        ST_AVG_WAIT,
        ST_DIV_GO,
        ST_DIV_WAIT,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_WRITE,
        OP_CHECK,
        OP_SAVE,
        OP_MEASURE
    } op_kind_t;

    typedef struct packed {
        op_kind_t          kind;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  val;
    } seq_op_t;

endpackage

// File: rtl/temp_seq_div.sv
module temp_seq_div #(
    parameter int W = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] num,
    input  logic        [W-1:0] den,
    output logic                done,
    output logic signed [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  q_r;
    logic [W-1:0]  d_r;
    logic [W:0]    r_r;
    logic [CW-1:0] cnt_r;
    logic          neg_r;
    logic          run_r;
    logic [W:0]    shifted;
    logic          fits;

    always_comb begin
        shifted = {r_r[W-1:0], q_r[W-1]};
        fits    = (shifted >= {1'b0, d_r});
    end

    // One quotient bit per cycle on the magnitude; sign applied at the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r   <= '0;
            d_r   <= '0;
            r_r   <= '0;
            cnt_r <= '0;
            neg_r <= 1'b0;
            run_r <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q_r   <= num[W-1] ? $unsigned(-num) : $unsigned(num);
                r_r   <= '0;
                d_r   <= den;
                neg_r <= num[W-1];
                cnt_r <= CW'(W);
                run_r <= 1'b1;
            end else if (run_r) begin
                r_r   <= fits ? (shifted - {1'b0, d_r}) : shifted;
                q_r   <= {q_r[W-2:0], fits};
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CW'(1)) begin
                    run_r <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quot = neg_r ? -$signed(q_r) : $signed(q_r);

    // R9: a finished division leaves a remainder below the divisor
    p_rem_below_den_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (r_r < {1'b0, d_r}));

endmodule

// File: rtl/temp_seq_poly.sv
module temp_seq_poly #(
    parameter int W = 48
) (
    input  logic signed [W-1:0] a,
    output logic signed [W-1:0] t
);
    localparam logic signed [W-1:0] C_SQ    = -559;
    localparam logic signed [W-1:0] C_SCALE = 1000;
    localparam logic signed [W-1:0] C_LIN   = 1379;
    localparam logic signed [W-1:0] C_OFF   = -458000;

    logic signed [W-1:0] sq;
    logic signed [W-1:0] quad;

    always_comb begin
        sq   = a * a;
        quad = (C_SQ * sq) / C_SCALE;
        t    = quad + C_LIN * a + C_OFF;
    end

endmodule

// File: rtl/temp_seq.sv
module temp_seq
    import temp_seq_pkg::*;
#(
    parameter int AVG_W  = 32,
    parameter int CALC_W = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    output logic                     busy,
    output logic                     done,
    output logic                     rw_err,
    output logic                     reg_req,
    output logic                     reg_we,
    output logic [ADDR_W-1:0]        reg_addr,
    output logic [REG_W-1:0]         reg_wdata,
    input  logic                     reg_ack,
    input  logic [REG_W-1:0]         reg_rdata,
    output logic                     avg_start,
    input  logic                     avg_done,
    input  logic [AVG_W-1:0]         avg_result,
    output logic signed [CALC_W-1:0] temp_out
);
    localparam int PAD = CALC_W - AVG_W;
    localparam logic signed [CALC_W-1:0] K_THOU = 1000;

    seq_state_t st, st_nx;
    seq_op_t    op;

    logic [STEP_W-1:0] step;
    logic [REG_W-1:0]  sv_pll, sv_tune, sv_dac;
    logic [AVG_W-1:0]  m1_q, m2_q;
    logic              err_q;
    logic signed [CALC_W-1:0] temp_q;

    logic [REG_W-1:0] pll_force, dac_force, tune_sel0, tune_sel1;
    logic [REG_W-1:0] pll_rest, dac_rest, tune_rest;

    logic signed [CALC_W-1:0] m1_s, m2_s, m2_e, num_s, den_s;
    logic signed [CALC_W-1:0] div_q, poly_t;
    logic                     div_go, div_done;

    function automatic seq_op_t mk_op(op_kind_t k, logic [ADDR_W-1:0] a, logic [REG_W-1:0] v);
        seq_op_t o;
        o.kind = k;
        o.addr = a;
        o.val  = v;
        return o;
    endfunction

    // Field patching of the saved test registers.
    always_comb begin
        pll_force = {sv_pll[15:13], 11'd512, sv_pll[1:0]};
        dac_force = {sv_dac[15], 3'd4, sv_dac[11:0]};
        tune_sel0 = {sv_tune[15:5], 1'b0, sv_tune[3:2], 2'b01};
        tune_sel1 = {sv_tune[15:5], 1'b1, sv_tune[3:2], 2'b01};
        pll_rest  = {pll_force[15:13], sv_pll[12:2], pll_force[1:0]};
        dac_rest  = {dac_force[15], sv_dac[14:12], dac_force[11:0]};
        tune_rest = {tune_sel1[15:5], sv_tune[4], tune_sel1[3:2], sv_tune[1:0]};
    end

    // Step table.
    always_comb begin
        op = mk_op(OP_WRITE, A_SCRATCH, '0);
        case (step)
            5'd0:  op = mk_op(OP_WRITE,   A_SCRATCH, 16'h0000);
            5'd1:  op = mk_op(OP_CHECK,   A_SCRATCH, 16'h0000);
            5'd2:  op = mk_op(OP_WRITE,   A_SCRATCH, 16'h5A5A);
            5'd3:  op = mk_op(OP_CHECK,   A_SCRATCH, 16'h5A5A);
            5'd4:  op = mk_op(OP_WRITE,   A_SCRATCH, 16'h1234);
            5'd5:  op = mk_op(OP_CHECK,   A_SCRATCH, 16'h1234);
            5'd6:  op = mk_op(OP_SAVE,    A_PLLTEST, '0);
            5'd7:  op = mk_op(OP_SAVE,    A_TUNE,    '0);
            5'd8:  op = mk_op(OP_SAVE,    A_DACCFG,  '0);
            5'd9:  op = mk_op(OP_WRITE,   A_PLLTEST, pll_force);
            5'd10: op = mk_op(OP_WRITE,   A_DACCFG,  dac_force);
            5'd11: op = mk_op(OP_WRITE,   A_TUNE,    tune_sel0);
            5'd12: op = mk_op(OP_MEASURE, A_TUNE,    '0);
            5'd13: op = mk_op(OP_WRITE,   A_TUNE,    tune_sel1);
            5'd14: op = mk_op(OP_MEASURE, A_TUNE,    '0);
            5'd15: op = mk_op(OP_WRITE,   A_PLLTEST, pll_rest);
            5'd16: op = mk_op(OP_WRITE,   A_DACCFG,  dac_rest);
            5'd17: op = mk_op(OP_WRITE,   A_TUNE,    tune_rest);
            default: op = mk_op(OP_WRITE, A_SCRATCH, '0);
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:      if (start) st_nx = ST_REG_ISSUE;
            ST_REG_ISSUE: if (reg_ack) st_nx = ST_STEP_NEXT;
            ST_STEP_NEXT: begin
                if (step == STEP_W'(STEP_END))  st_nx = ST_DIV_GO;
                else if (op.kind == OP_MEASURE) st_nx = ST_AVG_GO;
                else                            st_nx = ST_REG_ISSUE;
            end
            ST_AVG_GO:    st_nx = ST_AVG_WAIT;
            ST_AVG_WAIT:  if (avg_done) st_nx = ST_STEP_NEXT;
            ST_DIV_GO:    st_nx = ST_DIV_WAIT;
            ST_DIV_WAIT:  if (div_done) st_nx = ST_FINISH;
            ST_FINISH:    st_nx = ST_IDLE;
            default:      st_nx = ST_IDLE;
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step    <= '0;
            sv_pll  <= '0;
            sv_tune <= '0;
            sv_dac  <= '0;
            m1_q    <= '0;
            m2_q    <= '0;
            err_q   <= 1'b0;
            temp_q  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    step  <= '0;
                    err_q <= 1'b0;
                end
                ST_REG_ISSUE: if (reg_ack) begin
                    step <= step + 1'b1;
                    if (op.kind == OP_CHECK && reg_rdata != op.val) err_q <= 1'b1;
                    if (op.kind == OP_SAVE) begin
                        if (op.addr == A_PLLTEST) sv_pll  <= reg_rdata;
                        if (op.addr == A_TUNE)    sv_tune <= reg_rdata;
                        if (op.addr == A_DACCFG)  sv_dac  <= reg_rdata;
                    end
                end
                ST_AVG_WAIT: if (avg_done) begin
                    step <= step + 1'b1;
                    if (step == STEP_W'(STEP_M1)) m1_q <= avg_result;
                    if (step == STEP_W'(STEP_M2)) m2_q <= avg_result;
                end
                ST_DIV_WAIT: if (div_done) temp_q <= poly_t;
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        busy      = (st != ST_IDLE);
        done      = (st == ST_FINISH);
        reg_req   = (st == ST_REG_ISSUE);
        reg_we    = (op.kind == OP_WRITE);
        reg_addr  = op.addr;
        reg_wdata = reg_we ? op.val : '0;
        avg_start = (st == ST_AVG_GO);
        div_go    = (st == ST_DIV_GO);
        rw_err    = err_q;
        temp_out  = temp_q;
    end

    // Divider operands.
    always_comb begin
        m1_s  = $signed({{PAD{1'b0}}, m1_q});
        m2_s  = $signed({{PAD{1'b0}}, m2_q});
        m2_e  = ((m2_s / K_THOU) == '0) ? K_THOU : m2_s;
        num_s = m2_e - m1_s;
        den_s = m2_e / K_THOU;
    end

    temp_seq_div #(.W(CALC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_go),
        .num   (num_s),
        .den   ($unsigned(den_s)),
        .done  (div_done),
        .quot  (div_q)
    );

    temp_seq_poly #(.W(CALC_W)) u_poly (
        .a (div_q),
        .t (poly_t)
    );

    // R8: a pending command holds its fields until acknowledged
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: the result only moves together with done
    p_temp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(temp_out) || done));

    // R6: measurement launch is a single-cycle pulse
    p_avg_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        avg_start |=> !avg_start);

    // R3: a new run clears the mismatch flag
    p_err_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> !rw_err);

endmodule

// File: tb/temp_seq_bench.sv
module temp_seq_bench;
    localparam int CLK_NS = 10;
    localparam int AVG_W  = 32;
    localparam int CALC_W = 48;

    logic clk = 1'b0;
    logic rst_n, start, reg_ack, avg_done;
    logic busy, done, rw_err, reg_req, reg_we, avg_start;
    logic [15:0] reg_addr, reg_wdata, reg_rdata;
    logic [AVG_W-1:0] avg_result;
    logic signed [CALC_W-1:0] temp_out;

    temp_seq #(.AVG_W(AVG_W), .CALC_W(CALC_W)) u_temp_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .rw_err(rw_err), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .avg_start(avg_start), .avg_done(avg_done), .avg_result(avg_result),
        .temp_out(temp_out)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] mem [0:31];
    logic        l_we [0:31];
    logic [15:0] l_addr [0:31];
    logic [15:0] l_data [0:31];
    logic        e_we [0:15];
    logic [15:0] e_addr [0:15];
    logic [15:0] e_data [0:15];
    int          n_log;
    int          avg_at [0:3];
    int          n_avg;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint model_temp(longint m1, longint m2);
        longint m2e, a;
        m2e = m2;
        if (m2e / 1000 == 0) m2e = 1000;
        a = (m2e - m1) / (m2e / 1000);
        return (-559 * a * a) / 1000 + 1379 * a - 458000;
    endfunction

    task automatic set_exp(input int i, input logic we, input logic [15:0] a, input logic [15:0] d);
        e_we[i] = we; e_addr[i] = a; e_data[i] = d;
    endtask

    task automatic check_log(input int lo, input int hi, input string tag);
        bit ok = 1'b1;
        longint act = 0, exp = 0;
        for (int i = lo; i <= hi; i++) begin
            if (ok && (l_we[i] !== e_we[i] || l_addr[i] !== e_addr[i] || l_data[i] !== e_data[i])) begin
                ok  = 1'b0;
                act = longint'({l_we[i], l_addr[i], l_data[i]});
                exp = longint'({e_we[i], e_addr[i], e_data[i]});
            end
        end
        check(ok, tag, act, exp);
    endtask

    task automatic run_job(input logic [15:0] o_pll, input logic [15:0] o_tune, input logic [15:0] o_dac,
                           input int m1, input int m2, input int corrupt, input int lat);
        int lcnt = 0, acnt = 0, scr_rd = 0;
        bit apend = 1'b0, seen = 1'b0;
        logic [15:0] t0;
        mem[1] = 16'hFFFF; mem[8] = o_dac; mem[9] = o_tune; mem[23] = o_pll;
        t0 = (o_tune & ~16'h0013) | 16'h0001;
        set_exp(0, 1, 16'h0001, 16'h0000);   set_exp(1, 0, 16'h0001, 16'h0000);
        set_exp(2, 1, 16'h0001, 16'h5A5A);   set_exp(3, 0, 16'h0001, 16'h0000);
        set_exp(4, 1, 16'h0001, 16'h1234);   set_exp(5, 0, 16'h0001, 16'h0000);
        set_exp(6, 0, 16'h0017, 16'h0000);   set_exp(7, 0, 16'h0009, 16'h0000);
        set_exp(8, 0, 16'h0008, 16'h0000);
        set_exp(9, 1, 16'h0017, (o_pll & ~16'h1FFC) | 16'h0800);
        set_exp(10, 1, 16'h0008, (o_dac & ~16'h7000) | 16'h4000);
        set_exp(11, 1, 16'h0009, t0);        set_exp(12, 1, 16'h0009, t0 | 16'h0010);
        set_exp(13, 1, 16'h0017, o_pll);     set_exp(14, 1, 16'h0008, o_dac);
        set_exp(15, 1, 16'h0009, o_tune);
        n_log = 0; n_avg = 0;
        @(negedge clk); start = 1'b1;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            reg_ack = 1'b0; avg_done = 1'b0;
            start = (c == 4);          // stray start while busy (R11)
            if (done) begin seen = 1'b1; break; end
            if (reg_req) begin
                if (lcnt < lat) lcnt++;
                else begin
                    lcnt = 0;
                    if (n_log < 32) begin
                        l_we[n_log] = reg_we; l_addr[n_log] = reg_addr;
                        l_data[n_log] = reg_we ? reg_wdata : 16'h0000;
                    end
                    n_log++;
                    if (reg_we) mem[reg_addr[4:0]] = reg_wdata;
                    else begin
                        reg_rdata = mem[reg_addr[4:0]];
                        if (reg_addr == 16'h0001) begin
                            scr_rd++;
                            if (scr_rd == corrupt) reg_rdata = reg_rdata ^ 16'h0100;
                        end
                    end
                    reg_ack = 1'b1;
                end
            end
            if (avg_start) begin
                if (n_avg < 4) avg_at[n_avg] = n_log;
                n_avg++;
                check(mem[23][12:2] == 11'd512 && (mem[23] & ~16'h1FFC) == (o_pll & ~16'h1FFC),
                      "R5 pll field at measure", mem[23], (o_pll & ~16'h1FFC) | 16'h0800);
                check(mem[8][14:12] == 3'd4 && (mem[8] & ~16'h7000) == (o_dac & ~16'h7000),
                      "R5 dac field at measure", mem[8], (o_dac & ~16'h7000) | 16'h4000);
                check(mem[9] == (n_avg == 1 ? t0 : (t0 | 16'h0010)),
                      "R6 select bit at measure", mem[9], n_avg == 1 ? t0 : (t0 | 16'h0010));
                apend = 1'b1; acnt = lat + 2;
            end else if (apend) begin
                if (acnt == 0) begin
                    avg_done = 1'b1;
                    avg_result = AVG_W'(n_avg == 1 ? m1 : m2);
                    apend = 1'b0;
                end else acnt--;
            end
        end
        check(seen, "R10 done reached", seen, 1);
        check(longint'(temp_out) == model_temp(m1, m2), "R9 R10 temperature", temp_out, model_temp(m1, m2));
        check(rw_err == (corrupt != 0), "R3 mismatch flag", rw_err, corrupt != 0);
        check(n_log == 16, "R8 command count", n_log, 16);
        check_log(0, 5, "R2 scratch sequence");
        check_log(6, 8, "R4 save reads");
        check_log(9, 11, "R5 forced writes");
        check_log(12, 12, "R6 second select write");
        check(n_avg == 2 && avg_at[0] == 12 && avg_at[1] == 13, "R6 measure placement", avg_at[0], 12);
        check_log(13, 15, "R7 restore writes");
        check(mem[23] == o_pll && mem[8] == o_dac && mem[9] == o_tune, "R7 registers restored", mem[9], o_tune);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!busy && !reg_req && !done, "R11 idle after run", {busy, reg_req, done}, 0);
        end
    endtask

    initial begin
        #(CLK_NS * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R10 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int m1v [0:3];
        int m2v [0:4];
        int idx = 0;
        m1v = '{0, 700, 30000, 190000};
        m2v = '{0, 999, 1000, 25000, 180000};
        rst_n = 1'b0; start = 1'b0; reg_ack = 1'b0; avg_done = 1'b0;
        reg_rdata = '0; avg_result = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !reg_req && !avg_start && !rw_err, "R1 reset state",
              {busy, done, reg_req, avg_start, rw_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !reg_req, "R1 idle after release", {busy, reg_req}, 0);
        for (int i2 = 0; i2 < 5; i2++) begin
            for (int i1 = 0; i1 < 4; i1++) begin
                run_job(16'(16'h9ABC + idx * 16'h1357), 16'(16'h0FEE ^ (idx * 16'h0321)),
                        16'(16'hC0DE + idx * 16'h2468), m1v[i1], m2v[i2], idx % 4, idx % 3);
                idx++;
            end
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule